// File: doc/BRIEF.md
# Flash Read-Protection Mask with Commit

This block keeps a per-region read-enable mask for a 32 KB flash array cut into 2 KB regions. Software sees one 32-bit register. A write can only lower bits: the new mask is the old mask ANDed with the write data. A lowered bit closes its region to reads as soon as it is written. It stays volatile until software asks for a commit, which copies the live mask into a modelled non-volatile store.

A power-on reset pulse reloads the live mask from that store, so any bit that was lowered but never committed comes back up. A warm reset only clears the commit handshake and the check output. A separate check port takes a byte address and reports, one cycle later, whether reads from the region holding that address are allowed.

Top module: `flash_rdprot_guard`

## Requirements
- R1: With nothing committed, the first power-on pulse leaves `bus_rd_data` at 0x8000FFFF, with `commit_busy` and `commit_done` low.
- R2: A clock edge with `bus_wr_en` high sets mask bits [15:0] to their old value ANDed with `bus_wr_data[15:0]`, so a bit that is 0 can never be raised by a write.
- R3: `bus_rd_data[30:16]` always reads 0 and `bus_rd_data[31]` always reads 1, whatever was written to those bits.
- R4: An edge with `por` high loads the live mask from the committed store, which restores every bit lowered since the last commit. A write in the same cycle as `por` is lost.
- R5: An edge with `commit_req` high while `commit_busy` is low copies the live mask, as it was before that edge, into the store. `commit_busy` is then high for exactly one cycle, and `commit_done` pulses high for one cycle right after it while `commit_busy` returns low.
- R6: A `commit_req` seen while `commit_busy` is high has no effect. The store keeps its value, and a later `por` shows this.
- R7: An edge with `rst` high clears `commit_busy`, `commit_done` and `chk_ok`, and leaves both the live mask and the store as they were.
- R8: One cycle after an address is presented, `chk_ok` equals mask bit `chk_addr[14:11]` (region n covers bytes n*2048 to n*2048+2047). Any address of 32768 or more gives 0.
- R9: When a write and an accepted commit fall on the same edge, the store gets the mask as it was before the write. The write still lowers the live mask.
- R10: A lowered bit shows on `bus_rd_data` in the cycle after the write, and on `chk_ok` for an address presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous, active high |
| por | input | 1 | Power-on reset pulse, synchronous, active high; reloads the mask from the store |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_data | input | 32 | Write data, ANDed into the mask |
| bus_rd_data | output | 32 | Register view of the live mask |
| commit_req | input | 1 | Request to save the live mask into the store |
| commit_busy | output | 1 | Commit in progress |
| commit_done | output | 1 | One-cycle commit completion pulse |
| chk_addr | input | 16 | Byte address to check |
| chk_addr_ok | output | 1 | Registered read permission for the previous address |

## Verification
A live mask that went wrong shows on `bus_rd_data` in the cycle after the faulty edge, and on `chk_addr_ok` one cycle after any address in the affected region is checked. A wrong store cannot be seen directly. It stays hidden until the next `por`, so the bench pulses `por` often and compares the reloaded mask with its own model of the committed value. A stuck or stretched commit handshake shows at once on `commit_busy` and `commit_done`.

// File: rtl/rdprot_pkg.sv
package rdprot_pkg;
  localparam int REG_W = 32;
  typedef enum logic {CM_IDLE = 1'b0, CM_BUSY = 1'b1} commit_state_t;
endpackage

// File: rtl/rdprot_mask_store.sv
module rdprot_mask_store #(
  parameter int BLOCKS = 16
) (
  input  logic              clk,
  input  logic              por,
  input  logic              wr_en,
  input  logic [BLOCKS-1:0] wr_mask,
  input  logic              commit_take,
  output logic [BLOCKS-1:0] live_o
);
  localparam logic [BLOCKS-1:0] FACTORY = '1;

  // live mask and modelled non-volatile copy; the copy is never reset
  logic [BLOCKS-1:0] live_q  = FACTORY;
  logic [BLOCKS-1:0] store_q = FACTORY;

  always_ff @(posedge clk) begin
    if (por)        live_q <= store_q;
    else if (wr_en) live_q <= live_q & wr_mask;
  end

  always_ff @(posedge clk) begin
    if (commit_take) store_q <= live_q;
  end

  assign live_o = live_q;

  logic past_ok_q = 1'b0;
  always_ff @(posedge clk) past_ok_q <= 1'b1;

  assert_clear_only_R2: assert property (@(posedge clk) disable iff (por)
    (past_ok_q && !$past(por)) |-> ((live_q & ~$past(live_q)) == '0));
  assert_reload_R4: assert property (@(posedge clk)
    (past_ok_q && $past(por)) |-> (live_q == $past(store_q)));
  assert_commit_copy_R5: assert property (@(posedge clk)
    (past_ok_q && $past(commit_take)) |-> (store_q == $past(live_q)));
  assert_store_hold_R6: assert property (@(posedge clk)
    (past_ok_q && !$past(commit_take)) |-> $stable(store_q));
endmodule

// File: rtl/rdprot_commit_ctl.sv
module rdprot_commit_ctl
  import rdprot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic por,
  input  logic req,
  output logic take_o,
  output logic busy_o,
  output logic done_o
);
  commit_state_t state_q;
  logic          done_q;

  assign take_o = req && (state_q == CM_IDLE) && !rst && !por;

  always_ff @(posedge clk) begin
    if (rst || por) begin
      state_q <= CM_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q  <= (state_q == CM_BUSY);
      state_q <= take_o ? CM_BUSY : CM_IDLE;
    end
  end

  assign busy_o = (state_q == CM_BUSY);
  assign done_o = done_q;

  assert_busy_one_cycle_R5: assert property (@(posedge clk) disable iff (rst || por)
    busy_o |=> (!busy_o && done_o));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst || por)
    done_o |=> !done_o);
  assert_idle_req_starts_R5: assert property (@(posedge clk) disable iff (rst || por)
    (req && !busy_o) |=> busy_o);
endmodule

// File: rtl/rdprot_addr_check.sv
module rdprot_addr_check #(
  parameter int BLOCKS   = 16,
  parameter int BLK_LOG2 = 11,
  parameter int ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BLOCKS-1:0] live,
  output logic              ok_o
);
  localparam int IDX_W = $clog2(BLOCKS);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(BLOCKS) << BLK_LOG2;

  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic             ok_q;

  assign in_range = {1'b0, addr} < LIMIT;
  assign idx      = addr[BLK_LOG2 +: IDX_W];

  always_ff @(posedge clk) begin
    if (rst || por) ok_q <= 1'b0;
    else            ok_q <= in_range && live[idx];
  end

  assign ok_o = ok_q;

  assert_out_of_range_R8: assert property (@(posedge clk) disable iff (rst || por)
    ({1'b0, addr} >= LIMIT) |=> !ok_o);
endmodule

// File: rtl/flash_rdprot_guard.sv
module flash_rdprot_guard
  import rdprot_pkg::*;
#(
  parameter int BLOCKS   = 16,
  parameter int BLK_LOG2 = 11,
  parameter int ADDR_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             bus_wr_en,
  input  logic [REG_W-1:0] bus_wr_data,
  output logic [REG_W-1:0] bus_rd_data,
  input  logic             commit_req,
  output logic             commit_busy,
  output logic             commit_done,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic             chk_addr_ok
);
  localparam int PAD_W = REG_W - 1 - BLOCKS;

  logic [BLOCKS-1:0] live;
  logic              take;
  logic              wr_unused_hi;

  assign wr_unused_hi = ^bus_wr_data[REG_W-1:BLOCKS];

  rdprot_commit_ctl u_ctl (
    .clk(clk), .rst(rst), .por(por), .req(commit_req),
    .take_o(take), .busy_o(commit_busy), .done_o(commit_done)
  );

  rdprot_mask_store #(.BLOCKS(BLOCKS)) u_mask (
    .clk(clk), .por(por), .wr_en(bus_wr_en && !por),
    .wr_mask(bus_wr_data[BLOCKS-1:0]), .commit_take(take), .live_o(live)
  );

  rdprot_addr_check #(.BLOCKS(BLOCKS), .BLK_LOG2(BLK_LOG2), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .por(por), .addr(chk_addr), .live(live), .ok_o(chk_addr_ok)
  );

  // top bit fixed high, middle bits fixed low (R3)
  assign bus_rd_data = {1'b1, {PAD_W{1'b0}}, live};

  assert_view_fixed_R3: assert property (@(posedge clk)
    bus_rd_data[REG_W-1] && (bus_rd_data[REG_W-2:BLOCKS] == '0));
endmodule

// File: tb/flash_rdprot_guard_tb_top.sv
module flash_rdprot_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b0, por = 1'b0, bus_wr_en = 1'b0, commit_req = 1'b0;
  logic [31:0] bus_wr_data = '0;
  logic [15:0] chk_addr = '0;
  logic [31:0] bus_rd_data;
  logic commit_busy, commit_done, chk_addr_ok;

  int checks = 0, errors = 0;
  logic [15:0] m_live = 16'hFFFF, m_store = 16'hFFFF;
  logic m_busy = 1'b0, m_done = 1'b0, m_ok = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rdprot_guard dut_i (
    .clk(clk), .rst(rst), .por(por), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
    .bus_rd_data(bus_rd_data), .commit_req(commit_req), .commit_busy(commit_busy),
    .commit_done(commit_done), .chk_addr(chk_addr), .chk_addr_ok(chk_addr_ok)
  );

  function automatic logic [31:0] view(input logic [15:0] m);
    return {1'b1, 15'd0, m};
  endfunction

  function automatic logic region_ok(input logic [15:0] m, input logic [15:0] a);
    return (a < 16'h8000) ? m[a[14:11]] : 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [31:0] wd,
                      input logic rq, input logic [15:0] ad, input logic r, input logic p);
    logic [15:0] pre;
    logic take;
    bus_wr_en = we; bus_wr_data = wd; commit_req = rq; chk_addr = ad; rst = r; por = p;
    @(posedge clk);
    pre  = m_live;
    take = rq && !m_busy && !r && !p;
    if (take) m_store = pre;
    if (p) m_live = m_store;
    else if (we) m_live = pre & wd[15:0];
    if (r || p) begin
      m_busy = 1'b0; m_done = 1'b0; m_ok = 1'b0;
    end else begin
      m_done = m_busy; m_busy = take; m_ok = region_ok(pre, ad);
    end
    @(negedge clk);
    chk({tag, " rd_data"}, bus_rd_data, view(m_live));
    chk({tag, " busy"}, {31'd0, commit_busy}, {31'd0, m_busy});
    chk({tag, " done"}, {31'd0, commit_done}, {31'd0, m_done});
    chk({tag, " chk_ok"}, {31'd0, chk_addr_ok}, {31'd0, m_ok});
  endtask

  task automatic idle(input string tag, input logic [15:0] ad);
    step(tag, 1'b0, '0, 1'b0, ad, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    @(negedge clk);
    step("R1 power-on", 1'b0, '0, 1'b0, 16'h0, 1'b0, 1'b1);
    chk("R1 factory view", bus_rd_data, 32'h8000FFFF);
    // R2/R3: clear bit 0, try to raise upper and lower bits
    step("R2 clear bit0", 1'b1, 32'h7FFF_FFFE, 1'b0, 16'h0, 1'b0, 1'b0);
    step("R2 no raise", 1'b1, 32'hFFFF_FFFF, 1'b0, 16'h0000, 1'b0, 1'b0);
    chk("R3 fixed bits", bus_rd_data, 32'h8000FFFE);
    // R10/R8: region 0 closed, region 1 open, out of range closed
    idle("R10 region0", 16'h0000);
    chk("R10 region0 closed", {31'd0, chk_addr_ok}, 32'd0);
    idle("R8 region1", 16'h0800);
    chk("R8 region1 open", {31'd0, chk_addr_ok}, 32'd1);
    idle("R8 top of range", 16'h7FFF);
    idle("R8 beyond", 16'h8000);
    chk("R8 beyond closed", {31'd0, chk_addr_ok}, 32'd0);
    // R4: uncommitted clear returns
    step("R4 por", 1'b0, '0, 1'b0, 16'h0, 1'b0, 1'b1);
    chk("R4 restored", bus_rd_data, 32'h8000FFFF);
    // R5/R6: commit bit3 clear, request again while busy with bit5 cleared
    step("R5 clear bit3", 1'b1, 32'hFFFF_FFF7, 1'b0, 16'h0, 1'b0, 1'b0);
    step("R5 request", 1'b0, '0, 1'b1, 16'h0, 1'b0, 1'b0);
    chk("R5 busy", {31'd0, commit_busy}, 32'd1);
    step("R6 req while busy", 1'b1, 32'hFFFF_FFDF, 1'b1, 16'h0, 1'b0, 1'b0);
    chk("R5 done", {31'd0, commit_done}, 32'd1);
    commit_req = 1'b0;
    idle("R5 after", 16'h0);
    step("R6 por", 1'b0, '0, 1'b0, 16'h0, 1'b0, 1'b1);
    chk("R6 store kept", bus_rd_data, 32'h8000FFF7);
    // R7: warm reset during busy keeps mask
    step("R7 clear bit7", 1'b1, 32'hFFFF_FF7F, 1'b1, 16'h0, 1'b0, 1'b0);
    step("R7 warm reset", 1'b0, '0, 1'b0, 16'h0, 1'b1, 1'b0);
    chk("R7 mask kept", bus_rd_data, 32'h8000FF77);
    chk("R7 busy cleared", {31'd0, commit_busy}, 32'd0);
    // R9: write plus commit on the same edge, then power-on
    step("R9 write+commit", 1'b1, 32'hFFFF_FEFF, 1'b1, 16'h0, 1'b0, 1'b0);
    idle("R9 wait", 16'h0);
    idle("R9 wait2", 16'h0);
    step("R9 por", 1'b1, 32'h0, 1'b0, 16'h0, 1'b0, 1'b1);
    chk("R9 pre-write stored", bus_rd_data, 32'h8000FF77);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic we, rq, r, p;
      logic [31:0] wd;
      logic [15:0] ad;
      we = ($urandom % 4) == 0;
      wd = $urandom | $urandom | $urandom;
      rq = ($urandom % 8) == 0;
      r  = ($urandom % 100) == 0;
      p  = ($urandom % 40) == 0;
      ad = 16'($urandom);
      step("R2/R5/R8 random", we, wd, rq, ad, r, p);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule